// File: doc/BRIEF.md
# Transfer dispatcher run/stop/soft-reset controller

This block holds the six-bit control word of a scatter-gather DMA dispatcher. It turns that word into the permits that let the dispatcher hand out the next descriptor or the next read/write command. It raises a status bit once the engine has actually come to rest, and it runs a timed soft reset of the masters and FIFOs that reports its own progress. A CPU writes the control word through a simple word-addressed write port and can read it back at any time. The read and write masters report whether they are idle, and the dispatcher reports whether a command is still outstanding. The write master reports sink errors and length overruns as single-cycle pulses.

Two stop requests are kept apart. An immediate halt withdraws both permits, so nothing new is issued. A descriptor halt withdraws only the descriptor permit, so commands already taken can drain. Two optional sticky conditions freeze command issue after an error or a length overrun. They stay in force until a soft reset clears them. The interrupt enable masks only the registered interrupt output. The raw request, which the interrupt register logic upstream keeps pending, is never altered.

A single state machine in `xdc_fsm` has five states:
- ST_RUN: normal issue.
- ST_DRAINING: a stop is active but the masters are still busy.
- ST_HALTED: a stop is active and everything is quiet.
- ST_RST_HOLD: the soft reset pulse is driven.
- ST_RST_WAIT: the pulse has ended and the machine waits for the masters to go quiet.

Its transitions are:
- RUN→DRAINING when a stop appears while the masters are busy.
- RUN→HALTED when a stop appears while everything is quiet.
- DRAINING→HALTED when the engine becomes quiet.
- DRAINING/HALTED→RUN when the stop is withdrawn.
- HALTED→DRAINING when activity reappears.
- any run/stop state→RST_HOLD on a reset request.
- RST_HOLD→RST_WAIT when the pulse counter expires.
- RST_WAIT→RUN once quiet.

Top module: `xfer_dispatch_ctl`

## Requirements
- R1: After the hardware reset the control word reads 0, both permits are high, and `stat_stopped`, `stat_resetting`, `soft_rst` and `irq_out` are low.
- R2: Control bit 0 (immediate halt) drops both `desc_issue_ok` and `cmd_issue_ok` in the cycle after the accepting write. `stat_stopped` rises one cycle after a stop condition is seen together with both masters idle and `cmd_outstanding` low, and it never rises while they are busy.
- R3: Control bit 5 (descriptor halt) drops only `desc_issue_ok`, keeps `cmd_issue_ok` high, and produces `stat_stopped` by the same quiet rule as R2.
- R4: A write is accepted only when `cfg_wr_addr` is 0, `cfg_wr_be` is 4'hF and no soft reset is in progress. Any other write leaves the control word and the permits unchanged.
- R5: `cfg_rd_data` returns the control word in bits 5:0 and zero in bits 31:6.
- R6: With control bit 2 set, a `wr_sink_error` pulse latches a sticky halt that drops both permits. The halt persists even after bit 2 is cleared. A pulse while bit 2 is clear has no effect.
- R7: With control bit 3 set, a `wr_overrun` pulse latches a sticky halt with the same behaviour as R6. A pulse while bit 3 is clear has no effect.
- R8: `irq_out` equals `irq_raw` AND control bit 4, registered by one cycle.
- R9: Writing control bit 1 starts a soft reset. `soft_rst` is high for exactly RST_CYCLES cycles starting the cycle after the write. `stat_resetting` stays high from then until one cycle after the pulse has ended and the engine is quiet. Both permits stay low throughout.
- R10: When the soft reset finishes, the control word returns to 0 and both sticky halts are cleared. A reset request landing in the same cycle as an enabled error pulse wins, and the error is not latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_addr | input | ADDR_W | Word offset of the write |
| cfg_wr_data | input | DATA_W | Write data |
| cfg_wr_be | input | DATA_W/8 | Byte enables |
| cfg_rd_data | output | DATA_W | Current control word, upper bits zero |
| rd_master_idle | input | 1 | Read master has nothing in flight |
| wr_master_idle | input | 1 | Write master has nothing in flight |
| cmd_outstanding | input | 1 | A command has been handed out but not finished |
| wr_sink_error | input | 1 | Error pulse at the write master sink |
| wr_overrun | input | 1 | Write master tried to exceed the length field |
| irq_raw | input | 1 | Pending interrupt from the interrupt register logic |
| desc_issue_ok | output | 1 | Permit to hand out the next descriptor |
| cmd_issue_ok | output | 1 | Permit to issue the next read/write command |
| soft_rst | output | 1 | Soft reset to masters and FIFOs |
| stat_stopped | output | 1 | Engine halted and quiet |
| stat_resetting | output | 1 | Soft reset sequence in progress |
| irq_out | output | 1 | Masked interrupt |

## Verification
A soft reset request and an enabled error pulse can arrive in the same cycle. The sticky logic could then either latch the error or honour the clear. The bench first arms bit 2, then drives the reset write and the error pulse on the same clock edge. It judges the outcome after the reset completes: both permits must be back high and the control word zero. A second collision writes bit 2 in the same cycle as an error pulse. The pulse must be judged against the old control value, so nothing is latched.

// File: rtl/xdc_pkg.sv
package xdc_pkg;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_DRAINING,
        ST_HALTED,
        ST_RST_HOLD,
        ST_RST_WAIT
    } xdc_state_e;

    // Packed MSB first: field order fixes the bit positions of the control word.
    typedef struct packed {
        logic halt_desc;    // bit 5
        logic irq_en;       // bit 4
        logic halt_on_ovr;  // bit 3
        logic halt_on_err;  // bit 2
        logic soft_reset;   // bit 1
        logic halt_now;     // bit 0
    } xdc_ctrl_t;

    localparam int CTRL_W = $bits(xdc_ctrl_t);

endpackage

// File: rtl/xdc_regs.sv
module xdc_regs
    import xdc_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    localparam int BE_W = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [BE_W-1:0]   wr_be,
    input  logic              rst_busy,
    input  logic              rst_done,
    input  logic              err_evt,
    input  logic              ovr_evt,
    output xdc_ctrl_t         ctrl,
    output logic              err_stk,
    output logic              ovr_stk,
    output logic              rst_req,
    output logic [DATA_W-1:0] rd_data
);

    logic      wr_accept;
    xdc_ctrl_t wr_word;
    xdc_ctrl_t rst_word;

    always_comb begin
        wr_accept = wr_en && (wr_addr == '0) && (&wr_be) && !rst_busy;
        wr_word   = xdc_ctrl_t'(wr_data[CTRL_W-1:0]);
        rst_req   = wr_accept && wr_word.soft_reset;
        rst_word  = '0;
        rst_word.soft_reset = 1'b1;
        rd_data   = DATA_W'(ctrl);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (rst_done) begin
            ctrl <= '0;
        end else if (rst_req) begin
            ctrl <= rst_word;
        end else if (wr_accept) begin
            ctrl <= wr_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_stk <= 1'b0;
            ovr_stk <= 1'b0;
        end else if (rst_done || rst_req || rst_busy) begin
            err_stk <= 1'b0;
            ovr_stk <= 1'b0;
        end else begin
            if (err_evt && ctrl.halt_on_err) err_stk <= 1'b1;
            if (ovr_evt && ctrl.halt_on_ovr) ovr_stk <= 1'b1;
        end
    end

    AST_CTRL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_accept && !rst_done) |=> $stable(ctrl)); // R4

    AST_STICKY_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (err_stk && !rst_done && !rst_req && !rst_busy) |=> err_stk); // R6

    AST_STICKY_OVR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_stk && !rst_done && !rst_req && !rst_busy) |=> ovr_stk); // R7

endmodule

// File: rtl/xdc_fsm.sv
module xdc_fsm
    import xdc_pkg::*;
#(
    parameter int RST_CYCLES = 4,
    localparam int CNT_W = (RST_CYCLES < 2) ? 1 : $clog2(RST_CYCLES)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rst_req,
    input  logic stop_cond,
    input  logic quiet,
    output logic rst_busy,
    output logic rst_done,
    output logic soft_rst,
    output logic stopped
);

    xdc_state_e       state, nxt;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (nxt == ST_RST_HOLD && state != ST_RST_HOLD) begin
            cnt <= CNT_W'(RST_CYCLES - 1);
        end else if (state == ST_RST_HOLD && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_RUN: begin
                if (rst_req)        nxt = ST_RST_HOLD;
                else if (stop_cond) nxt = quiet ? ST_HALTED : ST_DRAINING;
            end
            ST_DRAINING: begin
                if (rst_req)         nxt = ST_RST_HOLD;
                else if (!stop_cond) nxt = ST_RUN;
                else if (quiet)      nxt = ST_HALTED;
            end
            ST_HALTED: begin
                if (rst_req)         nxt = ST_RST_HOLD;
                else if (!stop_cond) nxt = ST_RUN;
                else if (!quiet)     nxt = ST_DRAINING;
            end
            ST_RST_HOLD: begin
                if (cnt == '0) nxt = ST_RST_WAIT;
            end
            ST_RST_WAIT: begin
                if (quiet) nxt = ST_RUN;
            end
            default: nxt = ST_RUN;
        endcase
    end

    always_comb begin
        soft_rst = (state == ST_RST_HOLD);
        rst_busy = (state == ST_RST_HOLD) || (state == ST_RST_WAIT);
        rst_done = (state == ST_RST_WAIT) && quiet;
        stopped  = (state == ST_HALTED);
    end

    AST_STOPPED_AFTER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stopped) |-> $past(quiet) && $past(stop_cond)); // R2

    AST_SOFT_RST_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(soft_rst) |-> $past(rst_req)); // R9

endmodule

// File: rtl/xdc_irq_gate.sv
module xdc_irq_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_raw,
    input  logic irq_en,
    output logic irq_out
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_out <= 1'b0;
        else        irq_out <= irq_raw && irq_en;
    end

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> $past(irq_en) && $past(irq_raw)); // R8

endmodule

// File: rtl/xfer_dispatch_ctl.sv
module xfer_dispatch_ctl
    import xdc_pkg::*;
#(
    parameter int ADDR_W     = 4,
    parameter int DATA_W     = 32,
    parameter int RST_CYCLES = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_wr_en,
    input  logic [ADDR_W-1:0]   cfg_wr_addr,
    input  logic [DATA_W-1:0]   cfg_wr_data,
    input  logic [DATA_W/8-1:0] cfg_wr_be,
    output logic [DATA_W-1:0]   cfg_rd_data,
    input  logic                rd_master_idle,
    input  logic                wr_master_idle,
    input  logic                cmd_outstanding,
    input  logic                wr_sink_error,
    input  logic                wr_overrun,
    input  logic                irq_raw,
    output logic                desc_issue_ok,
    output logic                cmd_issue_ok,
    output logic                soft_rst,
    output logic                stat_stopped,
    output logic                stat_resetting,
    output logic                irq_out
);

    xdc_ctrl_t ctrl;
    logic      err_stk, ovr_stk, rst_req, rst_busy, rst_done;
    logic      quiet, stop_cond;

    always_comb begin
        quiet     = rd_master_idle && wr_master_idle && !cmd_outstanding;
        stop_cond = ctrl.halt_now || ctrl.halt_desc || err_stk || ovr_stk;
    end

    xdc_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_wr_en),
        .wr_addr  (cfg_wr_addr),
        .wr_data  (cfg_wr_data),
        .wr_be    (cfg_wr_be),
        .rst_busy (rst_busy),
        .rst_done (rst_done),
        .err_evt  (wr_sink_error),
        .ovr_evt  (wr_overrun),
        .ctrl     (ctrl),
        .err_stk  (err_stk),
        .ovr_stk  (ovr_stk),
        .rst_req  (rst_req),
        .rd_data  (cfg_rd_data)
    );

    xdc_fsm #(.RST_CYCLES(RST_CYCLES)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .rst_req   (rst_req),
        .stop_cond (stop_cond),
        .quiet     (quiet),
        .rst_busy  (rst_busy),
        .rst_done  (rst_done),
        .soft_rst  (soft_rst),
        .stopped   (stat_stopped)
    );

    xdc_irq_gate u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .irq_raw (irq_raw),
        .irq_en  (ctrl.irq_en),
        .irq_out (irq_out)
    );

    always_comb begin
        stat_resetting = rst_busy;
        cmd_issue_ok   = !rst_busy && !ctrl.halt_now && !err_stk && !ovr_stk;
        desc_issue_ok  = cmd_issue_ok && !ctrl.halt_desc;
    end

    AST_RST_NO_PERMIT: assert property (@(posedge clk) disable iff (!rst_n)
        stat_resetting |-> !desc_issue_ok && !cmd_issue_ok); // R9

    AST_HALT_BLOCKS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && cfg_wr_addr == '0 && (&cfg_wr_be) && !stat_resetting
         && cfg_wr_data[0] && !cfg_wr_data[1]) |=> !cmd_issue_ok); // R2

endmodule

// File: tb/xfer_dispatch_ctl_test.sv
module xfer_dispatch_ctl_test;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 4;
    localparam int DATA_W     = 32;
    localparam int RST_CYCLES = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_wr_en = 1'b0;
    logic [ADDR_W-1:0] cfg_wr_addr = '0;
    logic [DATA_W-1:0] cfg_wr_data = '0;
    logic [3:0]        cfg_wr_be = '0;
    logic [DATA_W-1:0] cfg_rd_data;
    logic rd_master_idle = 1'b1, wr_master_idle = 1'b1, cmd_outstanding = 1'b0;
    logic wr_sink_error = 1'b0, wr_overrun = 1'b0, irq_raw = 1'b0;
    logic desc_issue_ok, cmd_issue_ok, soft_rst, stat_stopped, stat_resetting, irq_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xfer_dispatch_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RST_CYCLES(RST_CYCLES)) uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_addr(cfg_wr_addr), .cfg_wr_data(cfg_wr_data),
        .cfg_wr_be(cfg_wr_be), .cfg_rd_data(cfg_rd_data),
        .rd_master_idle(rd_master_idle), .wr_master_idle(wr_master_idle),
        .cmd_outstanding(cmd_outstanding), .wr_sink_error(wr_sink_error),
        .wr_overrun(wr_overrun), .irq_raw(irq_raw),
        .desc_issue_ok(desc_issue_ok), .cmd_issue_ok(cmd_issue_ok), .soft_rst(soft_rst),
        .stat_stopped(stat_stopped), .stat_resetting(stat_resetting), .irq_out(irq_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Drive a write for one clock edge; returns at the negedge after it.
    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d, input logic [3:0] be);
        cfg_wr_en = 1'b1; cfg_wr_addr = a; cfg_wr_data = d; cfg_wr_be = be;
        @(negedge clk);
        cfg_wr_en = 1'b0; cfg_wr_addr = '0; cfg_wr_data = '0; cfg_wr_be = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset defaults
        check("R1 ctrl", cfg_rd_data, 32'h0);
        check("R1 desc_ok", desc_issue_ok, 1);
        check("R1 cmd_ok", cmd_issue_ok, 1);
        check("R1 stopped", stat_stopped, 0);
        check("R1 resetting", stat_resetting, 0);
        check("R1 soft_rst", soft_rst, 0);
        check("R1 irq", irq_out, 0);

        // R2 immediate halt while busy
        rd_master_idle = 1'b0;
        wr(0, 32'h1, 4'hF);
        check("R2 cmd_ok low", cmd_issue_ok, 0);
        check("R2 desc_ok low", desc_issue_ok, 0);
        tick(3);
        check("R2 not stopped while busy", stat_stopped, 0);
        rd_master_idle = 1'b1;
        cmd_outstanding = 1'b1;
        tick(2);
        check("R2 not stopped while outstanding", stat_stopped, 0);
        cmd_outstanding = 1'b0;
        tick(1);
        check("R2 stopped after quiet", stat_stopped, 1);
        wr(0, 32'h0, 4'hF);
        tick(1);
        check("R2 resumes", stat_stopped, 0);
        check("R2 cmd_ok back", cmd_issue_ok, 1);

        // R3/R5/R2/R8 sweep over every control value without bit 1
        irq_raw = 1'b1;
        for (int v = 0; v < 64; v++) begin
            if (v[1]) continue;
            wr(0, 32'hFFFF_FFC0 | v, 4'hF);
            check("R5 readback", cfg_rd_data, v);
            check("R2 cmd_ok sweep", cmd_issue_ok, !v[0]);
            check("R3 desc_ok sweep", desc_issue_ok, !(v[0] || v[5]));
            tick(1);
            check("R3 stopped sweep", stat_stopped, v[0] || v[5]);
            check("R8 irq sweep", irq_out, v[4]);
        end
        irq_raw = 1'b0;
        tick(1);
        check("R8 irq follows raw", irq_out, 0);

        // R4 ignored writes
        wr(0, 32'h10, 4'hF);
        tick(1);
        for (int be = 0; be < 15; be++) begin
            wr(0, 32'h21, be[3:0]);
            check("R4 partial be", cfg_rd_data, 32'h10);
            check("R4 partial be permit", cmd_issue_ok, 1);
        end
        for (int a = 1; a < 16; a++) begin
            wr(a[ADDR_W-1:0], 32'h21, 4'hF);
            check("R4 wrong offset", cfg_rd_data, 32'h10);
            check("R4 wrong offset permit", desc_issue_ok, 1);
        end

        // R6 sticky error
        wr(0, 32'h0, 4'hF);
        wr_sink_error = 1'b1; tick(1); wr_sink_error = 1'b0;
        check("R6 disabled error ignored", cmd_issue_ok, 1);
        wr(0, 32'h4, 4'hF);
        wr_sink_error = 1'b1; tick(1); wr_sink_error = 1'b0;
        check("R6 error halts", cmd_issue_ok, 0);
        wr(0, 32'h0, 4'hF);
        tick(1);
        check("R6 sticky after clear", cmd_issue_ok, 0);
        check("R6 stopped", stat_stopped, 1);

        // R9/R10 soft reset with busy masters
        wr_master_idle = 1'b0;
        wr(0, 32'h2, 4'hF);
        check("R9 soft_rst starts", soft_rst, 1);
        check("R9 resetting", stat_resetting, 1);
        check("R9 cmd_ok low", cmd_issue_ok, 0);
        tick(RST_CYCLES - 1);
        check("R9 soft_rst last cycle", soft_rst, 1);
        tick(1);
        check("R9 soft_rst ended", soft_rst, 0);
        check("R9 resetting waits", stat_resetting, 1);
        wr(0, 32'h11, 4'hF);
        tick(3);
        check("R9 still resetting", stat_resetting, 1);
        check("R9 desc_ok low", desc_issue_ok, 0);
        wr_master_idle = 1'b1;
        tick(1);
        check("R9 resetting done", stat_resetting, 0);
        check("R10 ctrl cleared", cfg_rd_data, 32'h0);
        check("R10 sticky cleared", cmd_issue_ok, 1);
        check("R4 write during reset dropped", desc_issue_ok, 1);

        // R7 sticky overrun
        wr_overrun = 1'b1; tick(1); wr_overrun = 1'b0;
        check("R7 disabled overrun ignored", cmd_issue_ok, 1);
        wr(0, 32'h8, 4'hF);
        wr_overrun = 1'b1; tick(1); wr_overrun = 1'b0;
        check("R7 overrun halts", cmd_issue_ok, 0);
        wr(0, 32'h0, 4'hF);
        check("R7 sticky after clear", desc_issue_ok, 0);
        wr(0, 32'h2, 4'hF);
        tick(RST_CYCLES + 1);
        check("R10 overrun cleared", cmd_issue_ok, 1);

        // R10 collision: reset request with enabled error in the same cycle
        wr(0, 32'h4, 4'hF);
        wr_sink_error = 1'b1;
        wr(0, 32'h2, 4'hF);
        wr_sink_error = 1'b0;
        tick(RST_CYCLES + 1);
        check("R10 collision resetting", stat_resetting, 0);
        check("R10 collision no latch", cmd_issue_ok, 1);
        check("R10 collision ctrl", cfg_rd_data, 32'h0);

        // R6 collision: enable written in the same cycle as an error pulse
        wr_sink_error = 1'b1;
        wr(0, 32'h4, 4'hF);
        wr_sink_error = 1'b0;
        tick(1);
        check("R6 old enable used", cmd_issue_ok, 1);

        finish_run();
    end

endmodule